// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a word-wide, memory-mapped general-purpose I/O controller. Its pins are grouped in banks of 32, and each bank has seven registers: a read-only synchronised pin level, a direction word, write-only set and clear ports for the output latch, rising and falling edge enables, and a sticky edge-status word. Bus writes take effect on the clock edge where the write enable is high. Reads are combinational from the current address.

Each pin input goes through a two-flop synchroniser. A pin whose edge enable matches the transition it sees latches a status bit. That bit stays set until software writes a one to it. Status bits 0 and 1 of the first bank each drive their own interrupt line. Every status bit in every bank feeds one combined interrupt. A parameterised run of pins uses inverted direction polarity, and the direction register resets so that all pins come up as inputs.

Banks are packed three to a 256-byte page. A bank's registers are interleaved with those of the other two banks in its page, at a 12-byte stride per register group.

Top module: `banked_pin_ctrl`

## Requirements
- R1: A register of group g (level 0, direction 1, set 2, clear 3, rising enable 4, falling enable 5, status 6) in bank n sits at byte address 0x100*(n/3) + 4*(n%3) + 12*g. A write reaches only that bank's register. A read of an address with no bank behind it, or with group 7 or above, returns zero.
- R2: A write to a bank's set port forces high every output-latch bit whose data bit is 1 and leaves the other bits unchanged. The latch appears on `pin_out` in the next cycle.
- R3: A write to a bank's clear port forces low every output-latch bit whose data bit is 1 and leaves the other bits unchanged.
- R4: After reset the output latch, the enables and the status are zero, `pin_oe` is all zero (every pin is an input), and all interrupt outputs are low.
- R5: For an ordinary pin, direction bit 1 drives `pin_oe` high. For pins INV_FIRST to INV_FIRST+INV_COUNT-1 (86 to 89 by default, bits 22 to 25 of bank 2) the polarity is inverted. Those direction bits therefore reset to 1 and read back as 1.
- R6: The level register shows a pin's value two clock edges after it changes. After one edge it still shows the old value.
- R7: A 0-to-1 transition of the synchronised pin sets its status bit when the pin's rising enable is 1.
- R8: A 1-to-0 transition sets the status bit when the falling enable is 1. With both enables set, both edges are captured.
- R9: A pin whose two enables are both 0 never sets a status bit, whatever its input does.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: When an edge event and a one-write clear hit the same status bit in the same cycle, the bit stays set.
- R12: `irq_any` is high while any status bit in any bank is set, and goes low only when all have been cleared.
- R13: `irq_pin0` and `irq_pin1` follow status bits 0 and 1 of bank 0 respectively.
- R14: Reads of the set and clear ports return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32*NUM_BANKS | Raw pin inputs |
| pin_out | output | 32*NUM_BANKS | Output latch |
| pin_oe | output | 32*NUM_BANKS | Output drive enable per pin |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_any | output | 1 | Combined interrupt of all status bits |

## Verification
Edge capture and the software clear of the status word can land on the same status bit in the same cycle. The bench provokes this with a pin whose status bit is already set and whose rising and falling enables are both on. It drops that pin and times the one-write clear so that the clear is sampled on the exact edge where the synchronised falling transition is recorded, three edges after the pin changed. It then judges the outcome by reading the status back: the bit must still be set. A plain clear issued afterwards must then empty the bit, and the combined interrupt must fall.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

  localparam int WORD_W         = 32;
  localparam int GROUPS         = 7;
  localparam int BANKS_PER_PAGE = 3;

  typedef enum logic [2:0] {
    RG_LEVEL = 3'd0,
    RG_DIR   = 3'd1,
    RG_SET   = 3'd2,
    RG_CLR   = 3'd3,
    RG_RISE  = 3'd4,
    RG_FALL  = 3'd5,
    RG_STAT  = 3'd6,
    RG_NONE  = 3'd7
  } reg_grp_e;

  typedef struct packed {
    logic     hit;
    reg_grp_e grp;
    logic [7:0] bank;
  } bus_sel_t;

  // Page = address bits 15:8, word-in-page = bits 7:2; word = 3*group + bank-in-page.
  function automatic bus_sel_t decode_addr(input logic [15:0] a, input int nbanks);
    bus_sel_t s;
    int w;
    int g;
    int b;
    w = int'(a[7:2]);
    g = w / BANKS_PER_PAGE;
    b = int'(a[15:8]) * BANKS_PER_PAGE + (w % BANKS_PER_PAGE);
    s.hit  = (a[1:0] == 2'b00) && (g < GROUPS) && (b < nbanks);
    s.grp  = s.hit ? reg_grp_e'(g[2:0]) : RG_NONE;
    s.bank = 8'(b);
    return s;
  endfunction

  // Bits of bank `bank` that fall inside the inverted-direction pin run.
  function automatic logic [WORD_W-1:0] inv_mask(input int bank, input int first, input int count);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) begin
      m[i] = ((bank * WORD_W + i) >= first) && ((bank * WORD_W + i) < first + count);
    end
    return m;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pin_bank.sv
module pin_bank
  import pinctl_pkg::*;
#(
  parameter logic [WORD_W-1:0] DIR_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] lvl,
  input  logic [WORD_W-1:0] wdata,
  input  logic              dir_we,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              rise_we,
  input  logic              fall_we,
  input  logic              stat_we,
  output logic [WORD_W-1:0] dir_q,
  output logic [WORD_W-1:0] out_q,
  output logic [WORD_W-1:0] rise_q,
  output logic [WORD_W-1:0] fall_q,
  output logic [WORD_W-1:0] stat_q
);
  logic [WORD_W-1:0] prev_lvl;
  logic [WORD_W-1:0] rose;
  logic [WORD_W-1:0] fell;
  logic [WORD_W-1:0] ev;
  logic [WORD_W-1:0] w1c;

  assign rose = lvl & ~prev_lvl;
  assign fell = ~lvl & prev_lvl;
  assign ev   = (rose & rise_q) | (fell & fall_q);
  assign w1c  = stat_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl <= '0;
      dir_q    <= DIR_INIT;
      out_q    <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      stat_q   <= '0;
    end else begin
      prev_lvl <= lvl;
      if (dir_we)  dir_q  <= wdata;
      if (rise_we) rise_q <= wdata;
      if (fall_we) fall_q <= wdata;
      if (set_we)       out_q <= out_q | wdata;
      else if (clr_we)  out_q <= out_q & ~wdata;
      stat_q <= (stat_q & ~w1c) | ev;
    end
  end

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n) set_we |=> ((out_q & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n) clr_we |=> ((out_q & $past(wdata)) == '0)); // R3
  AST_W1C_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) stat_we |=> ((stat_q & $past(wdata) & ~$past(ev)) == '0)); // R10
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n) (|ev) |=> ((stat_q & $past(ev)) == $past(ev))); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) ((stat_q & ~$past(stat_q) & ~$past(ev)) == '0)); // R7
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (((rise_q | fall_q) == '0) && !stat_we) |=> $stable(stat_q)); // R9
endmodule

// File: rtl/banked_pin_ctrl.sv
module banked_pin_ctrl
  import pinctl_pkg::*;
#(
  parameter int NUM_BANKS = 7,
  parameter int ADDR_W    = 12,
  parameter int INV_FIRST = 86,
  parameter int INV_COUNT = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_we,
  input  logic [WORD_W-1:0]             bus_wdata,
  output logic [WORD_W-1:0]             bus_rdata,
  input  logic [NUM_BANKS*WORD_W-1:0]   pin_in,
  output logic [NUM_BANKS*WORD_W-1:0]   pin_out,
  output logic [NUM_BANKS*WORD_W-1:0]   pin_oe,
  output logic                          irq_pin0,
  output logic                          irq_pin1,
  output logic                          irq_any
);
  localparam int NPINS = NUM_BANKS * WORD_W;

  logic [NPINS-1:0]  lvl_sync;
  bus_sel_t          sel;
  logic [WORD_W-1:0] dir_a  [NUM_BANKS];
  logic [WORD_W-1:0] out_a  [NUM_BANKS];
  logic [WORD_W-1:0] rise_a [NUM_BANKS];
  logic [WORD_W-1:0] fall_a [NUM_BANKS];
  logic [WORD_W-1:0] stat_a [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_pending;

  pin_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (lvl_sync)
  );

  assign sel = decode_addr(16'(bus_addr), NUM_BANKS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [WORD_W-1:0] INV = inv_mask(b, INV_FIRST, INV_COUNT);
    logic wr_here;
    assign wr_here = bus_we && sel.hit && (sel.bank == 8'(b));

    pin_bank #(.DIR_INIT(INV)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl_sync[b*WORD_W +: WORD_W]),
      .wdata   (bus_wdata),
      .dir_we  (wr_here && (sel.grp == RG_DIR)),
      .set_we  (wr_here && (sel.grp == RG_SET)),
      .clr_we  (wr_here && (sel.grp == RG_CLR)),
      .rise_we (wr_here && (sel.grp == RG_RISE)),
      .fall_we (wr_here && (sel.grp == RG_FALL)),
      .stat_we (wr_here && (sel.grp == RG_STAT)),
      .dir_q   (dir_a[b]),
      .out_q   (out_a[b]),
      .rise_q  (rise_a[b]),
      .fall_q  (fall_a[b]),
      .stat_q  (stat_a[b])
    );

    assign pin_out[b*WORD_W +: WORD_W] = out_a[b];
    assign pin_oe[b*WORD_W +: WORD_W]  = dir_a[b] ^ INV;
    assign bank_pending[b]             = |stat_a[b];
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel.hit && (sel.bank == 8'(b))) begin
        case (sel.grp)
          RG_LEVEL: bus_rdata = lvl_sync[b*WORD_W +: WORD_W];
          RG_DIR:   bus_rdata = dir_a[b];
          RG_RISE:  bus_rdata = rise_a[b];
          RG_FALL:  bus_rdata = fall_a[b];
          RG_STAT:  bus_rdata = stat_a[b];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq_pin0 = stat_a[0][0];
  assign irq_pin1 = stat_a[0][1];
  assign irq_any  = |bank_pending;

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (irq_any && !bus_we) |=> irq_any); // R12
  AST_WRITE_ONLY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (sel.hit && ((sel.grp == RG_SET) || (sel.grp == RG_CLR))) |-> (bus_rdata == '0)); // R14
endmodule

// File: tb/banked_pin_ctrl_test.sv
`timescale 1ns/1ps
module banked_pin_ctrl_test;
  localparam int NB = 7;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          irq_pin0, irq_pin1, irq_any;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        mon_ev;

  always #2.5 clk = ~clk;

  banked_pin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin0(irq_pin0),
    .irq_pin1(irq_pin1), .irq_any(irq_any)
  );

  // Address map restated: page per three banks, word stride per bank, 12 bytes per group.
  function automatic logic [11:0] reg_at(int bank, int grp);
    return 12'((bank / 3) * 256 + (bank % 3) * 4 + grp * 12);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops expected read data as each read is presented.
  initial forever begin
    @(mon_ev);
    chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    -> mon_ev;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    chk("R4 pin_oe bank0", pin_oe[31:0], 32'h0);
    chk("R4 pin_oe bank2", pin_oe[95:64], 32'h0);
    chk("R4 pin_out bank0", pin_out[31:0], 32'h0);
    chk("R4 irq lines", {29'h0, irq_pin0, irq_pin1, irq_any}, 32'h0);
    rd(reg_at(0, 1), 32'h0, "R4 dir bank0");
    rd(reg_at(6, 6), 32'h0, "R4 status bank6");
    rd(reg_at(2, 1), 32'h03C0_0000, "R5 inverted dir reset bank2");

    // R5 direction polarity
    wr(reg_at(2, 1), 32'hFFFF_FFFF);
    chk("R5 all dir ones bank2", pin_oe[95:64], 32'hFC3F_FFFF);
    wr(reg_at(2, 1), 32'h0);
    chk("R5 all dir zeros bank2", pin_oe[95:64], 32'h03C0_0000);
    wr(reg_at(2, 1), 32'h03C0_0000);
    chk("R5 back to input bank2", pin_oe[95:64], 32'h0);

    // R2 / R3 set and clear ports
    wr(reg_at(4, 2), 32'h0000_F0F0);
    chk("R2 set bank4", pin_out[159:128], 32'h0000_F0F0);
    wr(reg_at(4, 2), 32'h0000_0001);
    chk("R2 set keeps others", pin_out[159:128], 32'h0000_F0F1);
    wr(reg_at(4, 3), 32'h0000_F000);
    chk("R3 clear bank4", pin_out[159:128], 32'h0000_00F1);
    chk("R1 other bank untouched", pin_out[191:160], 32'h0);

    // R14 and R1 reads of write-only and unmapped addresses
    rd(reg_at(4, 2), 32'h0, "R14 set port reads zero");
    rd(reg_at(4, 3), 32'h0, "R14 clear port reads zero");
    rd(12'h054, 32'h0, "R1 group 7 reads zero");
    rd(12'h204, 32'h0, "R1 bank 7 slot reads zero");
    rd(12'h300, 32'h0, "R1 page 3 reads zero");

    // R1 layout: enable registers in several pages
    wr(reg_at(6, 4), 32'hA5A5_0000);
    wr(reg_at(5, 5), 32'h0000_5A5A);
    rd(reg_at(6, 4), 32'hA5A5_0000, "R1 bank6 rising enable");
    rd(reg_at(5, 5), 32'h0000_5A5A, "R1 bank5 falling enable");
    rd(reg_at(3, 5), 32'h0, "R1 bank3 falling untouched");
    wr(reg_at(6, 4), 32'h0);
    wr(reg_at(5, 5), 32'h0);

    // R6 two-flop synchroniser depth
    pin_in[35] = 1'b1;
    rd(reg_at(1, 0), 32'h0, "R6 level after one edge");
    rd(reg_at(1, 0), 32'h0000_0008, "R6 level after two edges");

    // R7 rising edge capture
    wr(reg_at(0, 4), 32'h0000_0020);
    pin_in[5] = 1'b1;
    settle();
    rd(reg_at(0, 6), 32'h0000_0020, "R7 rising captured");
    chk("R12 irq_any set", {31'h0, irq_any}, 32'h1);
    chk("R13 irq_pin0 quiet", {31'h0, irq_pin0}, 32'h0);

    // R10 write-one-to-clear
    wr(reg_at(0, 6), 32'h0000_0000);
    rd(reg_at(0, 6), 32'h0000_0020, "R10 zero write keeps bit");
    wr(reg_at(0, 6), 32'h0000_0020);
    rd(reg_at(0, 6), 32'h0, "R10 one write clears bit");
    chk("R12 irq_any clear", {31'h0, irq_any}, 32'h0);

    // R9 falling with only rising enabled, and an unenabled pin
    pin_in[5] = 1'b0;
    pin_in[6] = 1'b1;
    settle();
    pin_in[6] = 1'b0;
    settle();
    rd(reg_at(0, 6), 32'h0, "R9 no capture without enable");

    // R8 falling edge, both edges enabled
    wr(reg_at(0, 5), 32'h0000_0020);
    pin_in[5] = 1'b1;
    settle();
    rd(reg_at(0, 6), 32'h0000_0020, "R8 both: rising captured");
    wr(reg_at(0, 6), 32'h0000_0020);
    pin_in[5] = 1'b0;
    settle();
    rd(reg_at(0, 6), 32'h0000_0020, "R8 both: falling captured");

    // R11 edge and clear in the same cycle: bit is set, pin rises again then falls with a clear timed on the capture edge
    wr(reg_at(0, 6), 32'h0000_0020);
    pin_in[5] = 1'b1;
    settle();
    rd(reg_at(0, 6), 32'h0000_0020, "R11 setup bit set");
    @(negedge clk);
    pin_in[5] = 1'b0;
    @(negedge clk);
    wr(reg_at(0, 6), 32'h0000_0020);
    rd(reg_at(0, 6), 32'h0000_0020, "R11 event wins over clear");
    wr(reg_at(0, 6), 32'h0000_0020);
    rd(reg_at(0, 6), 32'h0, "R11 later clear empties");

    // R13 direct lines, R12 combined across banks
    wr(reg_at(0, 4), 32'h0000_0003);
    wr(reg_at(6, 5), 32'h0000_0001);
    pin_in[0] = 1'b1;
    settle();
    chk("R13 irq_pin0 follows bit0", {30'h0, irq_pin0, irq_pin1}, 32'h2);
    pin_in[1] = 1'b1;
    pin_in[192] = 1'b1;
    settle();
    chk("R13 irq_pin1 follows bit1", {30'h0, irq_pin0, irq_pin1}, 32'h3);
    pin_in[192] = 1'b0;
    settle();
    rd(reg_at(6, 6), 32'h0000_0001, "R8 bank6 falling captured");
    wr(reg_at(0, 6), 32'h0000_0003);
    chk("R13 direct lines cleared", {30'h0, irq_pin0, irq_pin1}, 32'h0);
    chk("R12 irq_any held by bank6", {31'h0, irq_any}, 32'h1);
    wr(reg_at(6, 6), 32'hFFFF_FFFF);
    chk("R12 irq_any falls when all clear", {31'h0, irq_any}, 32'h0);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard left %0d items", exp_q.size());
    end
    finish_run();
  end
endmodule